// File: doc/BRIEF.md
# Strap Latch and Test-Mode Controller

This block sits in the control logic of a clock synthesizer. At power-up it captures three frequency-select strap levels and a test-select strap, one time only, at the moment the active-low power-good qualifier first says the pins are valid. It holds those levels for register readback and decodes them into a CPU frequency code. The code is given as a multiple of the 33.33 MHz PCI clock. The SRC (100 MHz), PCI (33.33 MHz), USB (48 MHz) and DOT (96 MHz) rates do not depend on the code, so the block has no output for them.

A small state machine picks the output mode for the whole clock tree. The choices are normal clocks, every output in high impedance, or every output driven by a divided reference clock. Test mode can start in two ways: from the test-select strap at capture, or later from a register bit written over the serial interface. Each way uses its own source for the Hi-Z versus divided-reference choice. Once test mode is entered it holds until a full reset, which stands in for a power cycle.

The power-good qualifier and the real-time test pin are asynchronous. Each passes through a parameterised synchronizer. The strap levels are static while power-good settles. The two register bits come from logic on the same clock.

Top module: `strap_test_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `strap_rb` is 3'b000 and `out_mode` is 2'b00 (normal).
- R2: On the first cycle after reset where the synchronized `pwrgd_n` is low, the block captures the strap pins. `strap_rb[2]` then holds `fs_c`, `strap_rb[1]` holds `fs_b` and `strap_rb[0]` holds `fs_a`, and `strap_rb` shows them within SYNC_STAGES+2 cycles of `pwrgd_n` going low.
- R3: After capture, `strap_rb` and `cpu_mult` stay unchanged until the next reset, whatever the strap pins, `pwrgd_n` or `tsel_high` do.
- R4: `cpu_mult`, one cycle after `strap_rb`, equals CPU MHz divided by 33.33 for code {C,B,A}: 000→8 (266.66), 001→4 (133.33), 010→6 (200), 011→5 (166.66), 100→10 (333.33), 101→3 (100), 110→12 (400), and 111 (reserved)→0.
- R5: If `tsel_high` is 1 in the capture cycle, the block enters strap-entered test mode, and `out_mode` stops being 2'b00.
- R6: In strap-entered test mode, `out_mode` follows `test_pin` SYNC_STAGES+1 cycles later: a pin value of 0 gives 2'b01 (Hi-Z) and a pin value of 1 gives 2'b10 (divided reference). `out_mode` is never 2'b11.
- R7: In normal mode, `reg_test_en`=1 enters register-entered test mode. `out_mode` then becomes 2'b10 when `reg_refdiv_sel` is 1 and 2'b01 when it is 0, one cycle after the bit, and `test_pin` has no effect.
- R8: Test mode, from either source, is left only by `rst`. Clearing `reg_test_en` leaves `out_mode` unchanged.
- R9: In strap-entered test mode, `reg_refdiv_sel` and `reg_test_en` have no effect on `out_mode`.
- R10: With `tsel_high` 0 at capture and `reg_test_en` never set, `out_mode` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (stands in for a power cycle) |
| pwrgd_n | input | 1 | Asynchronous power-good qualifier; low means the strap pins are valid |
| fs_c | input | 1 | Frequency-select strap C logic level |
| fs_b | input | 1 | Frequency-select strap B |
| fs_a | input | 1 | Frequency-select strap A |
| tsel_high | input | 1 | Resolved flag: the shared C/test-select strap is at its high level |
| test_pin | input | 1 | Asynchronous real-time test-mode pin |
| reg_test_en | input | 1 | Register bit requesting test-mode entry |
| reg_refdiv_sel | input | 1 | Register bit choosing divided reference (1) or Hi-Z (0) in register-entered test |
| strap_rb | output | 3 | Captured straps {C,B,A} for read-only readback |
| cpu_mult | output | 4 | CPU frequency as a multiple of 33.33 MHz; 0 for the reserved code |
| out_mode | output | 2 | 00 normal, 01 all Hi-Z, 10 divided reference |

## Verification
The assertions check four properties on every cycle: the captured readback never changes once it is held, the reserved code always decodes to zero, `out_mode` never takes the unused encoding and never returns to normal outside reset, and in each test state `out_mode` tracks exactly the one select source that state owns. The bench scenarios cover the parts that span many cycles or depend on stimulus history. These are the full code table, the refusal to re-capture when straps and power-good toggle, the priority of the strap over the register path, and the fact that only a reset brings the block back to normal mode.

// File: rtl/strap_test_pkg.sv
package strap_test_pkg;

  localparam int FS_W   = 3;
  localparam int MULT_W = 4;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_TEST_STRAP = 2'd1,
    ST_TEST_REG   = 2'd2
  } tmode_state_e;

  localparam logic [MODE_W-1:0] OMODE_NORMAL = 2'b00;
  localparam logic [MODE_W-1:0] OMODE_HIZ    = 2'b01;
  localparam logic [MODE_W-1:0] OMODE_REFDIV = 2'b10;

  // CPU rate expressed as a multiple of the 33.33 MHz PCI rate
  function automatic logic [MULT_W-1:0] cpu_mult_of(input logic [FS_W-1:0] code);
    logic [MULT_W-1:0] m;
    case (code)
      3'b000:  m = 4'd8;
      3'b001:  m = 4'd4;
      3'b010:  m = 4'd6;
      3'b011:  m = 4'd5;
      3'b100:  m = 4'd10;
      3'b101:  m = 4'd3;
      3'b110:  m = 4'd12;
      default: m = 4'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int             WIDTH     = 1,
  parameter int             STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RESET_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RESET_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_test_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            qual_n_sync,
  input  logic [FS_W-1:0] fs_in,
  output logic            load,
  output logic            done,
  output logic [FS_W-1:0] fs_q
);
  logic done_q;

  assign load = !qual_n_sync && !done_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      fs_q   <= '0;
    end else if (load) begin
      done_q <= 1'b1;
      fs_q   <= fs_in;
    end
  end
endmodule

// File: rtl/freq_decode.sv
module freq_decode
  import strap_test_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FS_W-1:0]   code,
  output logic [MULT_W-1:0] mult_q
);
  always_ff @(posedge clk) begin
    if (rst) mult_q <= cpu_mult_of('0);
    else     mult_q <= cpu_mult_of(code);
  end
endmodule

// File: rtl/test_mode_fsm.sv
module test_mode_fsm
  import strap_test_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              tsel_high,
  input  logic              reg_enter,
  input  logic              reg_refdiv,
  input  logic              pin_sync,
  output tmode_state_e      state_q,
  output logic [MODE_W-1:0] out_mode_q
);
  tmode_state_e state_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_NORMAL) begin
      if (load && tsel_high) state_d = ST_TEST_STRAP;  // strap wins a same-cycle tie
      else if (reg_enter)    state_d = ST_TEST_REG;
    end
  end

  always_comb begin
    case (state_q)
      ST_TEST_STRAP: mode_d = pin_sync   ? OMODE_REFDIV : OMODE_HIZ;
      ST_TEST_REG:   mode_d = reg_refdiv ? OMODE_REFDIV : OMODE_HIZ;
      default:       mode_d = OMODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_NORMAL;
      out_mode_q <= OMODE_NORMAL;
    end else begin
      state_q    <= state_d;
      out_mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl
  import strap_test_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrgd_n,
  input  logic              fs_c,
  input  logic              fs_b,
  input  logic              fs_a,
  input  logic              tsel_high,
  input  logic              test_pin,
  input  logic              reg_test_en,
  input  logic              reg_refdiv_sel,
  output logic [FS_W-1:0]   strap_rb,
  output logic [MULT_W-1:0] cpu_mult,
  output logic [MODE_W-1:0] out_mode
);
  logic         pwrgd_n_sync;
  logic         pin_sync;
  logic         cap_load;
  logic         cap_done;
  tmode_state_e tm_state;

  sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst(rst), .d(pwrgd_n), .q(pwrgd_n_sync)
  );

  sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(test_pin), .q(pin_sync)
  );

  strap_capture u_cap (
    .clk(clk), .rst(rst), .qual_n_sync(pwrgd_n_sync),
    .fs_in({fs_c, fs_b, fs_a}), .load(cap_load), .done(cap_done), .fs_q(strap_rb)
  );

  freq_decode u_dec (
    .clk(clk), .rst(rst), .code(strap_rb), .mult_q(cpu_mult)
  );

  test_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .load(cap_load), .tsel_high(tsel_high),
    .reg_enter(reg_test_en), .reg_refdiv(reg_refdiv_sel), .pin_sync(pin_sync),
    .state_q(tm_state), .out_mode_q(out_mode)
  );
endmodule

// File: rtl/strap_test_ctrl_chk.sv
module strap_test_ctrl_chk
  import strap_test_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cap_done,
  input logic [FS_W-1:0]   strap_rb,
  input logic [MULT_W-1:0] cpu_mult,
  input logic [MODE_W-1:0] out_mode,
  input logic [1:0]        state,
  input logic              pin_sync,
  input logic              reg_refdiv
);
  AST_RB_HELD: assert property (@(posedge clk) disable iff (rst) (cap_done && $past(cap_done)) |-> $stable(strap_rb)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) cap_done |=> cap_done); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst) ($past(strap_rb) == 3'b111) |-> (cpu_mult == '0)); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) out_mode != 2'b11); // R6
  AST_STRAP_PIN: assert property (@(posedge clk) disable iff (rst) (state == ST_TEST_STRAP && $past(state) == ST_TEST_STRAP) |-> (out_mode == ($past(pin_sync) ? OMODE_REFDIV : OMODE_HIZ))); // R6
  AST_REG_SEL: assert property (@(posedge clk) disable iff (rst) (state == ST_TEST_REG && $past(state) == ST_TEST_REG) |-> (out_mode == ($past(reg_refdiv) ? OMODE_REFDIV : OMODE_HIZ))); // R7
  AST_TEST_STICKY: assert property (@(posedge clk) disable iff (rst) (out_mode != OMODE_NORMAL) |=> (out_mode != OMODE_NORMAL)); // R8
endmodule

bind strap_test_ctrl strap_test_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cap_done(cap_done), .strap_rb(strap_rb), .cpu_mult(cpu_mult),
  .out_mode(out_mode), .state(tm_state), .pin_sync(pin_sync), .reg_refdiv(reg_refdiv_sel)
);

// File: tb/strap_test_ctrl_tb_top.sv
module strap_test_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrgd_n = 1'b1;
  logic fs_c = 1'b0, fs_b = 1'b0, fs_a = 1'b0;
  logic tsel_high = 1'b0;
  logic test_pin = 1'b0;
  logic reg_test_en = 1'b0;
  logic reg_refdiv_sel = 1'b0;
  logic [2:0] strap_rb;
  logic [3:0] cpu_mult;
  logic [1:0] out_mode;

  int n_checks = 0;
  int n_errors = 0;

  always #5ns clk = ~clk;

  strap_test_ctrl dut_i (
    .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .fs_c(fs_c), .fs_b(fs_b), .fs_a(fs_a),
    .tsel_high(tsel_high), .test_pin(test_pin), .reg_test_en(reg_test_en),
    .reg_refdiv_sel(reg_refdiv_sel), .strap_rb(strap_rb), .cpu_mult(cpu_mult),
    .out_mode(out_mode)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] exp_mult(input logic [2:0] c);
    logic [3:0] r;
    unique case (c)
      3'd0: r = 8;   3'd1: r = 4;  3'd2: r = 6;  3'd3: r = 5;
      3'd4: r = 10;  3'd5: r = 3;  3'd6: r = 12; default: r = 0;
    endcase
    return r;
  endfunction

  // Reset with given straps; checks the reset-state outputs (R1)
  task automatic do_reset(input logic [2:0] code, input logic tsel);
    @(negedge clk);
    rst = 1'b1; pwrgd_n = 1'b1; reg_test_en = 1'b0; reg_refdiv_sel = 1'b0; test_pin = 1'b0;
    {fs_c, fs_b, fs_a} = code; tsel_high = tsel;
    cyc(3);
    check("R1 rb in reset", 8'(strap_rb), 8'd0);
    check("R1 mode in reset", 8'(out_mode), 8'd0);
    rst = 1'b0;
    cyc(1);
    check("R1 rb after reset", 8'(strap_rb), 8'd0);
    check("R1 mode after reset", 8'(out_mode), 8'd0);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c), 1'b0);
      pwrgd_n = 1'b0;
      cyc(6);
      check("R2 captured code", 8'(strap_rb), 8'(c));
      check("R4 cpu_mult", 8'(cpu_mult), 8'(exp_mult(3'(c))));
      check("R10 normal mode", 8'(out_mode), 8'd0);
      // R3: toggle straps and qualifier after capture
      {fs_c, fs_b, fs_a} = ~3'(c); tsel_high = 1'b1;
      pwrgd_n = 1'b1; cyc(4); pwrgd_n = 1'b0; cyc(6);
      check("R3 rb held", 8'(strap_rb), 8'(c));
      check("R3 mult held", 8'(cpu_mult), 8'(exp_mult(3'(c))));
      check("R10 late tsel ignored", 8'(out_mode), 8'd0);
    end
  endtask

  task automatic t_strap_test();
    do_reset(3'b101, 1'b1);
    pwrgd_n = 1'b0;
    cyc(6);
    check("R5 strap test hiz", 8'(out_mode), 8'd1);
    check("R2 rb in strap test", 8'(strap_rb), 8'd5);
    test_pin = 1'b1; cyc(4);
    check("R6 pin 1 refdiv", 8'(out_mode), 8'd2);
    test_pin = 1'b0; cyc(4);
    check("R6 pin 0 hiz", 8'(out_mode), 8'd1);
    reg_refdiv_sel = 1'b1; reg_test_en = 1'b1; cyc(4);
    check("R9 reg bits ignored", 8'(out_mode), 8'd1);
    reg_test_en = 1'b0; test_pin = 1'b1; cyc(4);
    check("R8 strap test held", 8'(out_mode), 8'd2);
  endtask

  task automatic t_reg_test();
    do_reset(3'b010, 1'b0);
    pwrgd_n = 1'b0;
    cyc(6);
    check("R10 before reg entry", 8'(out_mode), 8'd0);
    reg_test_en = 1'b1; reg_refdiv_sel = 1'b0; cyc(3);
    check("R7 reg hiz", 8'(out_mode), 8'd1);
    test_pin = 1'b1; cyc(4);
    check("R7 pin ignored", 8'(out_mode), 8'd1);
    reg_refdiv_sel = 1'b1; cyc(2);
    check("R7 reg refdiv", 8'(out_mode), 8'd2);
    reg_test_en = 1'b0; cyc(4);
    check("R8 clear bit no exit", 8'(out_mode), 8'd2);
    check("R3 rb in reg test", 8'(strap_rb), 8'd2);
    do_reset(3'b010, 1'b0);
    pwrgd_n = 1'b0; cyc(6);
    check("R8 reset exits test", 8'(out_mode), 8'd0);
  endtask

  initial begin
    t_codes();
    t_strap_test();
    t_reg_test();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1ms;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule